// File: doc/BRIEF.md
# Pipeline Bypass and Load-Stall Unit

This block is the purely combinational hazard logic of a five-stage in-order integer pipeline. The stages, in order, are fetch, decode, execute, memory and writeback. Operands are read in decode and results are written in writeback. An instruction that reads a register written by one of the two instructions directly ahead of it would therefore read a stale value.

The unit removes that problem in two ways. First, it compares both source registers of the instruction in execute with the destinations of the instructions in memory and writeback. For each ALU input it produces a 2-bit select that picks the register-file value, the writeback-stage value or the memory-stage value. Second, it detects a load in execute whose destination is read by the instruction in decode. In that case it raises, for one cycle, a hold for fetch, a hold for decode and a squash that turns the execute slot into a no-op. The cycle after that, the loaded value reaches writeback and is bypassed from there.

The register file, ALU, branch logic and memories sit outside this block. The pipeline registers around the unit apply its holds and squash.

Top module: `bypass_stall_unit`

## Requirements
- R1: An execute source equal to the memory-stage destination, with the memory-stage write enable set and that destination not 0, gives select 2'b10 for that operand.
- R2: An execute source equal to the writeback-stage destination (write enable set, destination not 0) and not matched by the memory stage gives select 2'b01.
- R3: When the memory stage and the writeback stage both match a source, the select is 2'b10, because the memory stage holds the newer value.
- R4: Register 0 never matches. A stage whose write enable is clear never matches. With no match the select is 2'b00 (register file).
- R5: Operand A follows execute source 1 and operand B follows execute source 2, each decided independently by R1 to R4.
- R6: A load in execute with a nonzero destination equal to either decode source drives holdFetch, holdDecode and squashExec to 1 in the same cycle.
- R7: Without that condition, all three stall outputs are 0. This covers a load writing register 0, a load with no consumer, and a non-load producer directly ahead of its consumer.
- R8: The three stall outputs are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exSrc1 | input | 5 | First source register of the instruction in execute |
| exSrc2 | input | 5 | Second source register of the instruction in execute |
| exIsLoad | input | 1 | Instruction in execute is a load |
| exDst | input | 5 | Destination register of the instruction in execute |
| idSrc1 | input | 5 | First source register of the instruction in decode |
| idSrc2 | input | 5 | Second source register of the instruction in decode |
| memDst | input | 5 | Destination register of the memory-stage instruction |
| memWrEn | input | 1 | Memory-stage instruction writes a register |
| wbDst | input | 5 | Destination register of the writeback-stage instruction |
| wbWrEn | input | 1 | Writeback-stage instruction writes a register |
| selA | output | 2 | ALU input A source: 00 register file, 01 writeback, 10 memory |
| selB | output | 2 | ALU input B source: same encoding as selA |
| holdFetch | output | 1 | Keep the fetch stage and program counter unchanged |
| holdDecode | output | 1 | Keep the decode pipeline register unchanged |
| squashExec | output | 1 | Load a no-op into execute on the next edge |

## Verification
Every output is a combinational function of the current inputs, so each result is due in the same cycle as the stimulus that causes it. The bench changes the pipeline-stage fields just after a rising edge and samples the outputs at the following falling edge, well away from any edge. Multi-instruction sequences (back-to-back, two apart, load followed by its consumer) are modelled as successive cycles of stage contents. The check for each cycle is made in that cycle. The bubble cycle is followed by a cycle in which the loaded value must come from writeback.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    OPND_REGFILE = 2'b00,
    OPND_WB      = 2'b01,
    OPND_MEM     = 2'b10
  } opndSelT;

  typedef struct packed {
    logic holdFetch;
    logic holdDecode;
    logic squashExec;
  } stallStrobesT;
endpackage

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             exIsLoad,
  input  logic [REG_W-1:0] exDst,
  input  logic [REG_W-1:0] idSrc1,
  input  logic [REG_W-1:0] idSrc2,
  output stallStrobesT     strobes
);
  logic loadUse;

  assign loadUse = exIsLoad && (exDst != '0) &&
                   ((exDst == idSrc1) || (exDst == idSrc2));

  always_comb begin
    strobes.holdFetch  = loadUse;
    strobes.holdDecode = loadUse;
    strobes.squashExec = loadUse;
  end

  always_comb begin
    // R7
    zeroLoadNoStall_chk: assert (exDst != '0 || !strobes.holdFetch);
    // R7
    nonLoadNoStall_chk: assert (exIsLoad || !strobes.squashExec);
  end
endmodule

// File: rtl/fwd_path.sv
module fwd_path
  import hazard_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int N_OPND = 2,
  localparam int SEL_W = 2
) (
  input  logic [N_OPND*REG_W-1:0] exSrc,
  input  logic [REG_W-1:0]        memDst,
  input  logic                    memWrEn,
  input  logic [REG_W-1:0]        wbDst,
  input  logic                    wbWrEn,
  input  stallStrobesT            strobes,
  output logic [N_OPND*SEL_W-1:0] sel,
  output logic                    holdFetch,
  output logic                    holdDecode,
  output logic                    squashExec
);
  for (genvar g = 0; g < N_OPND; g++) begin : gOpnd
    logic [REG_W-1:0] src;
    logic             hitMem;
    logic             hitWb;
    opndSelT          pick;

    assign src    = exSrc[g*REG_W +: REG_W];
    assign hitMem = memWrEn && (memDst != '0) && (memDst == src);
    assign hitWb  = wbWrEn && (wbDst != '0) && (wbDst == src);

    always_comb begin
      if (hitMem)      pick = OPND_MEM;
      else if (hitWb)  pick = OPND_WB;
      else             pick = OPND_REGFILE;
    end

    assign sel[g*SEL_W +: SEL_W] = pick;

    always_comb begin
      // R4
      zeroSrc_chk: assert (src != '0 || pick == OPND_REGFILE);
      // R3
      memPrio_chk: assert (!(hitMem && hitWb) || pick == OPND_MEM);
      // R4
      noWriter_chk: assert (memWrEn || wbWrEn || pick == OPND_REGFILE);
    end
  end

  assign holdFetch  = strobes.holdFetch;
  assign holdDecode = strobes.holdDecode;
  assign squashExec = strobes.squashExec;
endmodule

// File: rtl/bypass_stall_unit.sv
module bypass_stall_unit
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] exSrc1,
  input  logic [REG_W-1:0] exSrc2,
  input  logic             exIsLoad,
  input  logic [REG_W-1:0] exDst,
  input  logic [REG_W-1:0] idSrc1,
  input  logic [REG_W-1:0] idSrc2,
  input  logic [REG_W-1:0] memDst,
  input  logic             memWrEn,
  input  logic [REG_W-1:0] wbDst,
  input  logic             wbWrEn,
  output logic [1:0]       selA,
  output logic [1:0]       selB,
  output logic             holdFetch,
  output logic             holdDecode,
  output logic             squashExec
);
  localparam int N_OPND = 2;

  stallStrobesT strobes;
  logic [N_OPND*2-1:0] selBus;

  hazard_ctrl #(.REG_W(REG_W)) uCtrl (
    .exIsLoad (exIsLoad),
    .exDst    (exDst),
    .idSrc1   (idSrc1),
    .idSrc2   (idSrc2),
    .strobes  (strobes)
  );

  fwd_path #(.REG_W(REG_W), .N_OPND(N_OPND)) uPath (
    .exSrc      ({exSrc2, exSrc1}),
    .memDst     (memDst),
    .memWrEn    (memWrEn),
    .wbDst      (wbDst),
    .wbWrEn     (wbWrEn),
    .strobes    (strobes),
    .sel        (selBus),
    .holdFetch  (holdFetch),
    .holdDecode (holdDecode),
    .squashExec (squashExec)
  );

  assign selA = selBus[1:0];
  assign selB = selBus[3:2];

  always_comb begin
    // R8
    stallAgree_chk: assert (holdFetch == squashExec && holdDecode == squashExec);
  end
endmodule

// File: tb/bypass_stall_unit_test.sv
module bypass_stall_unit_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0] exSrc1, exSrc2, exDst, idSrc1, idSrc2, memDst, wbDst;
  logic exIsLoad, memWrEn, wbWrEn;
  logic [1:0] selA, selB;
  logic holdFetch, holdDecode, squashExec;

  int checks = 0;
  int errors = 0;

  bypass_stall_unit uut (.*);

  task automatic idle();
    @(posedge clk); #0.5;
    exSrc1 = 0; exSrc2 = 0; exDst = 0; idSrc1 = 0; idSrc2 = 0;
    memDst = 0; wbDst = 0; exIsLoad = 0; memWrEn = 0; wbWrEn = 0;
  endtask

  task automatic expectSel(string req, logic [1:0] expA, logic [1:0] expB);
    @(negedge clk);
    checks++;
    if (selA !== expA || selB !== expB) begin
      errors++;
      $display("FAIL %s: selA=%b selB=%b expected %b %b", req, selA, selB, expA, expB);
    end
  endtask

  task automatic expectStall(string req, logic exp);
    checks++;
    if (holdFetch !== exp || holdDecode !== exp || squashExec !== exp) begin
      errors++;
      $display("FAIL %s: stall=%b%b%b expected %b%b%b", req,
               holdFetch, holdDecode, squashExec, exp, exp, exp);
    end
  endtask

  task automatic resetState();
    idle();
    expectSel("R4 idle", 2'b00, 2'b00);
    expectStall("R7 idle", 1'b0);
  endtask

  // add r2 ; add r?,r2,r2 ; add r?,r2,r3 : producer in mem then wb
  task automatic backToBack();
    idle(); exSrc1 = 2; exSrc2 = 2; memDst = 2; memWrEn = 1; idSrc1 = 2;
    expectSel("R1 back-to-back", 2'b10, 2'b10);
    expectStall("R7 alu producer no stall", 1'b0);
    idle(); exSrc1 = 3; exSrc2 = 2; wbDst = 2; wbWrEn = 1; memDst = 9; memWrEn = 1;
    expectSel("R2 two apart", 2'b00, 2'b01);
  endtask

  task automatic independentOps();
    idle(); exSrc1 = 7; exSrc2 = 8; memDst = 8; memWrEn = 1; wbDst = 7; wbWrEn = 1;
    expectSel("R5 independent operands", 2'b01, 2'b10);
  endtask

  task automatic doubleMatch();
    idle(); exSrc1 = 5; exSrc2 = 5; memDst = 5; memWrEn = 1; wbDst = 5; wbWrEn = 1;
    expectSel("R3 double match", 2'b10, 2'b10);
    idle(); exSrc1 = 5; exSrc2 = 6; memDst = 5; memWrEn = 0; wbDst = 5; wbWrEn = 1;
    expectSel("R3 mem disabled falls to wb", 2'b01, 2'b00);
  endtask

  task automatic zeroAndNoWrite();
    idle(); exSrc1 = 0; exSrc2 = 0; memDst = 0; memWrEn = 1; wbDst = 0; wbWrEn = 1;
    expectSel("R4 register 0", 2'b00, 2'b00);
    idle(); exSrc1 = 4; exSrc2 = 4; memDst = 4; memWrEn = 0; wbDst = 4; wbWrEn = 0;
    expectSel("R4 write enable clear", 2'b00, 2'b00);
  endtask

  task automatic loadUse();
    // lw r9 in execute, consumer in decode reads r9 on source 2
    idle(); exIsLoad = 1; exDst = 9; idSrc1 = 1; idSrc2 = 9;
    expectSel("R6 load-use sel", 2'b00, 2'b00);
    expectStall("R6 load-use src2", 1'b1);
    // bubble now in mem, load in wb, consumer in execute
    idle(); exSrc1 = 1; exSrc2 = 9; memDst = 0; memWrEn = 0; wbDst = 9; wbWrEn = 1;
    expectSel("R2 load value from wb", 2'b00, 2'b01);
    expectStall("R7 after bubble", 1'b0);
    idle(); exIsLoad = 1; exDst = 11; idSrc1 = 11; idSrc2 = 3;
    expectSel("R6 load-use src1 sel", 2'b00, 2'b00);
    expectStall("R6 load-use src1", 1'b1);
    idle(); exIsLoad = 1; exDst = 0; idSrc1 = 0; idSrc2 = 0;
    expectSel("R7 load r0 sel", 2'b00, 2'b00);
    expectStall("R7 load to r0", 1'b0);
    idle(); exIsLoad = 1; exDst = 12; idSrc1 = 13; idSrc2 = 14;
    expectSel("R7 load no consumer sel", 2'b00, 2'b00);
    expectStall("R7 load no consumer", 1'b0);
    idle(); exIsLoad = 0; exDst = 12; idSrc1 = 12; idSrc2 = 12;
    expectSel("R7 alu dep sel", 2'b00, 2'b00);
    expectStall("R8 non-load dependency", 1'b0);
  endtask

  initial begin
    fork
      begin
        resetState();
        backToBack();
        independentOps();
        doubleMatch();
        zeroAndNoWrite();
        loadUse();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule